// File: doc/BRIEF.md
# Byte-Stream Command Ingress Controller

This block sits between a narrow host port and a block-oriented hashing core. The host drives one byte per cycle under a valid qualifier, with a 2-bit command code on every byte. One port carries both kinds of traffic. Setup bytes collect into a ten-byte job description: a key length, a digest length and a 64-bit message length. Message bytes collect into a 64-byte block that is handed to the core. The core takes the block with a simple busy/ready handshake.

Flow control works per block, not per byte. Once the host sees the ready output high, it may push a whole block without looking at ready again. The ready output is registered through a two-stage pipeline, so the host sees it two clock edges after the internal condition changes. The valid input may drop at any point inside a setup packet or a block; the byte positions hold and pick up where they left off. Bytes that arrive in the wrong context are dropped and change no state.

Top module: `bstream_ingress`

## Requirements
- R1: While `rst_n` is low and after it is released, `host_ready`, `cfg_valid` and `blk_ready` are 0, and the block waits for a setup packet.
- R2: Ten accepted bytes with `in_cmd`=0 form the setup packet, little endian: byte 0 is the key length, byte 1 is the digest length, and bytes 2 to 9 are the message length, least significant byte first. `cfg_valid` and the decoded fields appear on the edge that accepts the tenth byte.
- R3: A setup packet whose key length exceeds 32 leaves `cfg_valid` low. Message bytes sent afterwards are dropped.
- R4: A byte with `in_cmd`=0, accepted while no block is partly filled or pending, starts a new setup packet. `cfg_valid` falls on that edge and stays low until ten bytes have been taken.
- R5: While the block is configured and no block is pending, a byte with `in_cmd` of 1, 2 or 3 is stored at the next block position. Byte k appears at `blk_data[8k+7:8k]`. `blk_ready` rises on the edge that accepts the 64th byte.
- R6: `blk_first` is 1 only if the block's byte 0 carried `in_cmd`=1. `blk_last` is 1 only if its byte 63 carried `in_cmd`=3. `in_cmd`=2 marks an ordinary message byte.
- R7: Cycles with `in_valid` low do not move the setup or block position. Transfers resume at the position where they stopped.
- R8: A pending block keeps `blk_ready`, `blk_data` and the flags steady while `core_busy` is high. `blk_ready` falls on the edge after a cycle with `blk_ready` high and `core_busy` low, so it is high for one cycle when the core is free.
- R9: The block is internally ready when it holds a valid setup, no block is partly filled and none is pending. `host_ready` equals that condition as it stood two rising edges earlier.
- R10: These bytes are dropped and change no state: message bytes before a valid setup, a byte with `in_cmd`=0 inside a partly filled or pending block, and message bytes while a block is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Host byte qualifier |
| in_cmd | input | 2 | 0 setup, 1 first message byte, 2 message byte, 3 final message byte |
| in_data | input | 8 | Host byte |
| core_busy | input | 1 | Core cannot take a block this cycle |
| host_ready | output | 1 | A whole block may be sent (two-edge latency) |
| cfg_valid | output | 1 | Setup packet complete and accepted |
| cfg_key_len | output | 8 | Key length in bytes |
| cfg_hash_len | output | 8 | Digest length in bytes |
| cfg_msg_len | output | 64 | Message length in bytes |
| blk_data | output | 512 | Assembled block, byte k at bits 8k+7:8k |
| blk_first | output | 1 | Block opened with the first-byte code |
| blk_last | output | 1 | Block closed with the final-byte code |
| blk_ready | output | 1 | Block pending for the core |

## Verification
Each output has a fixed due time. The setup fields and `cfg_valid` follow the tenth setup byte one edge later. `blk_ready` follows the 64th message byte one edge later and falls one edge after the core is free. `host_ready` trails the internal ready condition by two edges. The bench drives on falling edges and counts edges from the accepting edge. It samples at the falling edge where each result is due and also at the edges just before it, so that early or late ready changes are caught. A scoreboard queue holds each block the driver sends, and the monitor compares the block, its flags and any unexpected block at the moment `blk_ready` rises.

// File: rtl/bsi_pkg.sv
package bsi_pkg;
  localparam int unsigned CFG_BYTES = 10;
  localparam int unsigned LEN_W     = 64;

  typedef enum logic [1:0] {
    CMD_SETUP = 2'd0,
    CMD_OPEN  = 2'd1,
    CMD_BODY  = 2'd2,
    CMD_CLOSE = 2'd3
  } cmd_e;

  // setup accepted only when key length is within limit
  function automatic logic key_len_ok(input logic [7:0] klen, input int unsigned lim);
    return ({24'd0, klen} <= lim);
  endfunction

  // block position after one accepted byte, wrapping at the block size
  function automatic int unsigned next_pos(input int unsigned pos, input int unsigned nbytes);
    return (pos + 1 == nbytes) ? 0 : pos + 1;
  endfunction
endpackage

// File: rtl/bsi_cfg_rx.sv
module bsi_cfg_rx
  import bsi_pkg::*;
#(
  parameter int unsigned KEY_MAX = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [7:0]       byte_in,
  output logic [7:0]       key_len,
  output logic [7:0]       hash_len,
  output logic [LEN_W-1:0] msg_len,
  output logic             cfg_ok
);
  localparam int unsigned SR_W = CFG_BYTES * 8;
  localparam int unsigned CW   = $clog2(CFG_BYTES + 1);

  logic [SR_W-1:0] sr_q;
  logic [CW-1:0]   cnt_q;
  logic            full;

  assign full = (cnt_q == CW'(CFG_BYTES));

  // bytes enter at the top; after ten shifts byte 0 sits in the low lane
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (take) begin
      sr_q  <= {byte_in, sr_q[SR_W-1:8]};
      cnt_q <= full ? CW'(1) : cnt_q + CW'(1);
    end
  end

  assign key_len  = sr_q[7:0];
  assign hash_len = sr_q[15:8];
  assign msg_len  = sr_q[SR_W-1:16];
  assign cfg_ok   = full && key_len_ok(key_len, KEY_MAX);

  a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(cnt_q));
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    take && full |=> !cfg_ok);
endmodule

// File: rtl/bsi_blk_rx.sv
module bsi_blk_rx
  import bsi_pkg::*;
#(
  parameter int unsigned BLK_BYTES = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   take,
  input  logic [1:0]             cmd,
  input  logic [7:0]             byte_in,
  input  logic                   core_busy,
  output logic [BLK_BYTES*8-1:0] blk_data,
  output logic                   blk_first,
  output logic                   blk_last,
  output logic                   blk_ready,
  output logic                   blk_idle
);
  localparam int unsigned PW = $clog2(BLK_BYTES);

  logic [PW-1:0] pos_q;
  logic          pend_q, first_q, last_q;
  logic          wrap, hand;
  logic [7:0]    lane_q [BLK_BYTES];

  assign wrap = take && (pos_q == PW'(BLK_BYTES - 1));
  assign hand = pend_q && !core_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      pend_q  <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      if (take) begin
        pos_q <= PW'(next_pos(int'(pos_q), BLK_BYTES));
        if (pos_q == '0) first_q <= (cmd == CMD_OPEN);
      end
      if (wrap) begin
        last_q <= (cmd == CMD_CLOSE);
        pend_q <= 1'b1;
      end else if (hand) begin
        pend_q <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < BLK_BYTES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           lane_q[i] <= '0;
      else if (take && pos_q == PW'(i))     lane_q[i] <= byte_in;
    end
    assign blk_data[i*8 +: 8] = lane_q[i];
  end

  assign blk_first = first_q;
  assign blk_last  = last_q;
  assign blk_ready = pend_q;
  assign blk_idle  = (pos_q == '0) && !pend_q;

  a_r5_complete: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> blk_ready);
  a_r8_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && core_busy |=> pend_q && $stable(blk_data));
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    hand |=> !blk_ready);
  a_r7_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(pos_q));
  a_r10_no_take_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !take);
endmodule

// File: rtl/bsi_rdy_dly.sv
module bsi_rdy_dly #(
  parameter int unsigned LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [LAT-1:0] sh_q;

  if (LAT == 1) begin : g_one
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= d;
    end
  end else begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[LAT-2:0], d};
    end
  end

  assign q = sh_q[LAT-1];
endmodule

// File: rtl/bstream_ingress.sv
module bstream_ingress
  import bsi_pkg::*;
#(
  parameter int unsigned BLK_BYTES = 64,
  parameter int unsigned KEY_MAX   = 32,
  parameter int unsigned RDY_LAT   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [1:0]             in_cmd,
  input  logic [7:0]             in_data,
  input  logic                   core_busy,
  output logic                   host_ready,
  output logic                   cfg_valid,
  output logic [7:0]             cfg_key_len,
  output logic [7:0]             cfg_hash_len,
  output logic [LEN_W-1:0]       cfg_msg_len,
  output logic [BLK_BYTES*8-1:0] blk_data,
  output logic                   blk_first,
  output logic                   blk_last,
  output logic                   blk_ready
);
  logic cfg_ok, blk_idle, cfg_take, dat_take, rdy_int;

  // routing of each host byte; out-of-context bytes take neither path
  assign cfg_take = in_valid && (in_cmd == CMD_SETUP) && blk_idle;
  assign dat_take = in_valid && (in_cmd != CMD_SETUP) && cfg_ok && !blk_ready;
  assign rdy_int  = cfg_ok && blk_idle;

  bsi_cfg_rx #(.KEY_MAX(KEY_MAX)) cfg_i (
    .clk(clk), .rst_n(rst_n), .take(cfg_take), .byte_in(in_data),
    .key_len(cfg_key_len), .hash_len(cfg_hash_len), .msg_len(cfg_msg_len),
    .cfg_ok(cfg_ok)
  );

  bsi_blk_rx #(.BLK_BYTES(BLK_BYTES)) blk_i (
    .clk(clk), .rst_n(rst_n), .take(dat_take), .cmd(in_cmd), .byte_in(in_data),
    .core_busy(core_busy), .blk_data(blk_data), .blk_first(blk_first),
    .blk_last(blk_last), .blk_ready(blk_ready), .blk_idle(blk_idle)
  );

  bsi_rdy_dly #(.LAT(RDY_LAT)) rdy_i (
    .clk(clk), .rst_n(rst_n), .d(rdy_int), .q(host_ready)
  );

  assign cfg_valid = cfg_ok;

  if (RDY_LAT == 2) begin : g_lat_chk
    a_r9_ready_lat: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready == $past(rdy_int, 2));
  end

  a_r9_fall_on_open: assert property (@(posedge clk) disable iff (!rst_n)
    dat_take && blk_idle |=> !rdy_int);
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_idle |=> $stable(cfg_ok));
endmodule

// File: tb/bstream_ingress_tb_top.sv
`timescale 1ns/1ps
module bstream_ingress_tb_top;
  localparam int BB = 64;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, core_busy = 1'b0;
  logic [1:0] in_cmd = 2'd0;
  logic [7:0] in_data = 8'd0;
  logic host_ready, cfg_valid, blk_first, blk_last, blk_ready;
  logic [7:0] cfg_key_len, cfg_hash_len;
  logic [63:0] cfg_msg_len;
  logic [BB*8-1:0] blk_data;

  int n_tests = 0, n_fail = 0;
  bit seen = 1'b0;
  logic [BB*8-1:0] q_data [$];
  logic q_first [$];
  logic q_last [$];

  always #2 clk = ~clk;

  bstream_ingress dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cmd(in_cmd), .in_data(in_data),
    .core_busy(core_busy), .host_ready(host_ready), .cfg_valid(cfg_valid),
    .cfg_key_len(cfg_key_len), .cfg_hash_len(cfg_hash_len), .cfg_msg_len(cfg_msg_len),
    .blk_data(blk_data), .blk_first(blk_first), .blk_last(blk_last), .blk_ready(blk_ready)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed * 37 + k * 11 + 5) & 255);
  endfunction

  function automatic logic [BB*8-1:0] blk_exp(input int seed);
    logic [BB*8-1:0] d;
    for (int k = 0; k < BB; k++) d[k*8 +: 8] = pat(seed, k);
    return d;
  endfunction

  function automatic logic [7:0] cfg_b(input logic [7:0] k, input logic [7:0] h,
                                       input logic [63:0] l, input int i);
    if (i == 0) return k;
    if (i == 1) return h;
    return l[(i-2)*8 +: 8];
  endfunction

  task automatic put(input logic [1:0] c, input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_cmd = c; in_data = d;
    @(posedge clk);
    #0.5;
    in_valid = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  // probe: check host_ready fall after byte 0 and inject a setup byte mid-block
  task automatic send_blk(input int seed, input bit first, input bit last,
                          input bit push, input bit probe);
    if (push) begin
      q_data.push_back(blk_exp(seed));
      q_first.push_back(first);
      q_last.push_back(last);
    end
    for (int k = 0; k < BB; k++) begin
      logic [1:0] c;
      c = (k == 0 && first) ? 2'd1 : ((k == BB-1 && last) ? 2'd3 : 2'd2);
      put(c, pat(seed, k));
      if (probe && k == 0) begin
        @(negedge clk); check("R9 ready still up 0 edges", 64'(host_ready), 64'd1);
        @(negedge clk); check("R9 ready still up 1 edge", 64'(host_ready), 64'd1);
        @(negedge clk); check("R9 ready down 2 edges", 64'(host_ready), 64'd0);
        put(2'd0, 8'hAA);  // R10 setup byte inside block
        gap(1);
        check("R10 setup untouched", 64'(cfg_valid), 64'd1);
        check("R10 key untouched", 64'(cfg_key_len), 64'd1);
      end
      if (k == 30) gap(3);  // R7 gap mid-block
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n || !blk_ready) seen = 1'b0;
      else if (!seen) begin
        seen = 1'b1;
        if (q_data.size() == 0) begin
          n_tests++; n_fail++;
          $display("FAIL R10 unexpected block actual=1 expected=0");
        end else begin
          logic [BB*8-1:0] ed;
          ed = q_data.pop_front();
          n_tests++;
          if (blk_data !== ed) begin
            n_fail++;
            $display("FAIL R5 block data actual=%h expected=%h", blk_data, ed);
          end
          check("R6 first flag", 64'(blk_first), 64'(q_first.pop_front()));
          check("R6 last flag", 64'(blk_last), 64'(q_last.pop_front()));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    gap(6);
    check("R1 ready in reset", 64'(host_ready), 64'd0);
    check("R1 cfg in reset", 64'(cfg_valid), 64'd0);
    check("R1 blk in reset", 64'(blk_ready), 64'd0);
    rst_n = 1'b1;
    gap(3);
    check("R1 ready after reset", 64'(host_ready), 64'd0);

    // R10 message bytes before any setup
    send_blk(9, 1'b1, 1'b0, 1'b0, 1'b0);
    gap(6);
    check("R10 no block before setup", 64'(blk_ready), 64'd0);
    check("R10 no ready before setup", 64'(host_ready), 64'd0);

    // R2 setup with a gap (R7)
    for (int i = 0; i < 9; i++) begin
      put(2'd0, cfg_b(8'd1, 8'd32, 64'd67, i));
      if (i == 3) gap(4);
    end
    gap(1);
    check("R2 not valid after nine", 64'(cfg_valid), 64'd0);
    put(2'd0, cfg_b(8'd1, 8'd32, 64'd67, 9));
    @(negedge clk);
    check("R2 cfg valid", 64'(cfg_valid), 64'd1);
    check("R2 key len", 64'(cfg_key_len), 64'd1);
    check("R2 hash len", 64'(cfg_hash_len), 64'd32);
    check("R2 msg len", cfg_msg_len, 64'd67);
    check("R9 ready 0 edges", 64'(host_ready), 64'd0);
    @(negedge clk); check("R9 ready 1 edge", 64'(host_ready), 64'd0);
    @(negedge clk); check("R9 ready 2 edges", 64'(host_ready), 64'd1);

    // block 1, core busy
    core_busy = 1'b1;
    send_blk(1, 1'b1, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    check("R5 blk ready after 64th", 64'(blk_ready), 64'd1);
    gap(5);
    check("R8 held while busy", 64'(blk_ready), 64'd1);
    n_tests++;
    if (blk_data !== blk_exp(1)) begin
      n_fail++;
      $display("FAIL R8 data held actual=%h expected=%h", blk_data, blk_exp(1));
    end
    check("R9 no ready while pending", 64'(host_ready), 64'd0);
    put(2'd2, 8'h11); put(2'd2, 8'h22); put(2'd3, 8'h33);  // R10 bytes while pending
    @(negedge clk);
    core_busy = 1'b0;
    @(negedge clk);
    check("R8 released", 64'(blk_ready), 64'd0);
    gap(3);
    check("R9 ready after handoff", 64'(host_ready), 64'd1);

    // block 2, core free: one-cycle strobe
    send_blk(2, 1'b0, 1'b1, 1'b1, 1'b0);
    @(negedge clk); check("R8 strobe high", 64'(blk_ready), 64'd1);
    @(negedge clk); check("R8 strobe one cycle", 64'(blk_ready), 64'd0);
    gap(3);

    // R4 restart
    put(2'd0, 8'd0);
    gap(1);
    check("R4 restart drops valid", 64'(cfg_valid), 64'd0);
    for (int i = 1; i < 10; i++) put(2'd0, cfg_b(8'd0, 8'd16, 64'd5, i));
    gap(1);
    check("R4 new cfg valid", 64'(cfg_valid), 64'd1);
    check("R4 new key len", 64'(cfg_key_len), 64'd0);
    check("R4 new hash len", 64'(cfg_hash_len), 64'd16);
    check("R4 new msg len", cfg_msg_len, 64'd5);
    gap(3);
    send_blk(3, 1'b1, 1'b1, 1'b1, 1'b0);  // R6 both flags
    gap(4);

    // R3 oversize key
    for (int i = 0; i < 10; i++) put(2'd0, cfg_b(8'd33, 8'd32, 64'd64, i));
    gap(1);
    check("R3 oversize key rejected", 64'(cfg_valid), 64'd0);
    gap(3);
    check("R3 no ready", 64'(host_ready), 64'd0);
    send_blk(4, 1'b1, 1'b1, 1'b0, 1'b0);
    gap(4);
    check("R3 data dropped", 64'(blk_ready), 64'd0);
    check("R5 all blocks delivered", 64'(q_data.size()), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule